// File: doc/BRIEF.md
# Long-frame PCM serial port

This block connects a voice codec core to a framed serial PCM line that carries one 8-bit companded sample per 8 kHz frame. The transmit half and the receive half each have their own bit clock and frame sync. The two halves can be driven from one shared clock pair (synchronous use) or from two unrelated ones (asynchronous use). All serial inputs are sampled by a much faster system clock through synchronizers, so every serial timing point below is accurate to within a few system cycles.

On the transmit side, a parallel byte enters through a valid/ready handshake and sits in a holding register. Each frame sync moves it into the shifter. The port measures each transmit sync pulse and uses that width to decide whether the line runs in long-frame mode. Only in long-frame mode does it drive the data output, together with an output-enable that controls an external tri-state buffer. On the receive side, the port assembles a byte from the serial input and reports it with a one-cycle valid pulse. It also flags a frame whose shortened sync marks the least significant bit as signalling, and flags a sync pulse that is too short. A programmable number of system cycles after each received byte, it raises a decode-update strobe.

The receive byte stream has no back-pressure: `rx_valid` is a single-cycle pulse that the consumer must take when it appears. On the transmit stream, `tx_ready` stays low while the holding register carries a byte that no frame has taken yet. If no new byte is offered before a frame starts, the previous byte is sent again.

Top module: `pcm_lf_port`

## Requirements
- R1: The width of a sync pulse is the number of falling bit-clock edges seen while that sync is high, saturating at 3. When the transmit sync falls, `tx_long` becomes 1 if the width was 3 or more and 0 otherwise. After reset `tx_long` is 1.
- R2: A frame is armed only if `tx_long` is 1 at the transmit sync rising edge. `tx_oe` then rises at the later of that sync rising edge and the next transmit bit-clock rising edge, and `tx_dout` presents bit 7 (the sign bit) first.
- R3: `tx_ready` is 1 after reset and whenever the holding register is empty. An accepted byte (`tx_valid` and `tx_ready` both high at a clock edge) drops `tx_ready` until the next transmit sync rising edge takes the byte. A frame that starts with no new byte resends the last byte; the holding register resets to 8'hFF.
- R4: The seven transmit bit-clock rising edges after the first bit shift out bits 6 down to 0, MSB first. `tx_dout` is 0 whenever `tx_oe` is 0.
- R5: `tx_oe` falls at the later of two events: the falling bit-clock edge after the eighth rising edge, and the transmit sync going low. A sync that ends before the eighth bit does not cut the frame short.
- R6: After a receive sync rising edge, the next eight falling edges of the receive bit clock capture `rx_din`, MSB first. The byte appears on `rx_data` with a one-cycle `rx_valid` pulse after the eighth bit.
- R7: `rx_sig` is 1 with `rx_valid` exactly when the receive sync width is 2. This marks bit 0 as signalling rather than voice.
- R8: `rx_err` is 1 with `rx_valid` exactly when the receive sync width is below 2. A width of 3 or more sets neither flag, and the two flags are never both 1.
- R9: Taking D = `dec_dly` (with 0 treated as 1), `dec_strobe` pulses for one cycle exactly D+1 system cycles after `rx_valid`. A new `rx_valid` restarts the count.
- R10: The receive half works from its own bit clock and sync, with no dependence on the transmit clocks. Receive activity alone never asserts `tx_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bclk | input | 1 | Transmit bit clock (asynchronous) |
| tx_fsync | input | 1 | Transmit frame sync (asynchronous) |
| tx_data | input | DW | Transmit byte from the encoder side |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty, byte can be accepted |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for the external tri-state buffer |
| tx_long | output | 1 | Long-frame mode from the last transmit sync width |
| rx_bclk | input | 1 | Receive bit clock (asynchronous) |
| rx_fsync | input | 1 | Receive frame sync (asynchronous) |
| rx_din | input | 1 | Serial receive data |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` and the flags are new |
| rx_sig | output | 1 | Bit 0 of the byte is signalling |
| rx_err | output | 1 | Receive sync was shorter than two bit periods |
| dec_dly | input | DLY_W | Decode-update delay in system cycles |
| dec_strobe | output | 1 | Decode-update strobe |

## Verification
A corrupted transmit bit counter shows up at once as a wrong bit on `tx_dout` within the same frame, or as `tx_oe` held past the ninth bit period. A wrong mode register shows up one frame later, as a whole frame driven or silent against expectation. On the receive side, a bad capture counter or width counter reveals itself at the end of that same frame, through a wrong byte, a missing or doubled `rx_valid`, or wrong flags. A timer fault is seen as a strobe distance other than D+1 measured from that pulse.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // sync width thresholds, in falling bit-clock edges seen while sync is high
  localparam int unsigned WIDTH_BITS = 2;
  localparam logic [WIDTH_BITS-1:0] WIDTH_SIG  = 2'd2;
  localparam logic [WIDTH_BITS-1:0] WIDTH_LONG = 2'd3;

  typedef enum logic [1:0] {
    SYNC_RUNT = 2'd0,
    SYNC_SIG  = 2'd1,
    SYNC_LONG = 2'd2
  } sync_class_e;

  function automatic sync_class_e classify(input logic [WIDTH_BITS-1:0] w);
    if (w >= WIDTH_LONG)     return SYNC_LONG;
    else if (w == WIDTH_SIG) return SYNC_SIG;
    else                     return SYNC_RUNT;
  endfunction
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] pipe [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else if (g == 0) pipe[g] <= async_i;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/pcm_width_meter.sv
module pcm_width_meter
  import pcm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fs_rise,
  input  logic                  fs_lvl,
  input  logic                  bclk_fall,
  output logic [WIDTH_BITS-1:0] width_d
);
  logic [WIDTH_BITS-1:0] width_q;

  always_comb begin
    width_d = width_q;
    if (fs_rise) width_d = '0;
    else if (fs_lvl && bclk_fall && width_q != WIDTH_LONG) width_d = width_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= '0;
    else width_q <= width_d;
  end
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          fs_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          dout_o,
  output logic          oe_o,
  output logic          long_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  logic [1:0] s;
  logic bclk, fs, bclk_q, fs_q;
  logic b_rise, b_fall, f_rise, f_fall;
  logic [WIDTH_BITS-1:0] width_d;

  pcm_sync #(.N(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({fs_i, bclk_i}), .sync_o(s)
  );
  assign bclk = s[0];
  assign fs   = s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      fs_q   <= fs;
    end
  end

  assign b_rise = bclk & ~bclk_q;
  assign b_fall = ~bclk & bclk_q;
  assign f_rise = fs & ~fs_q;
  assign f_fall = ~fs & fs_q;

  pcm_width_meter u_meter (
    .clk(clk), .rst_n(rst_n), .fs_rise(f_rise), .fs_lvl(fs),
    .bclk_fall(b_fall), .width_d(width_d)
  );

  logic [DW-1:0] hold, shreg;
  logic          full, active, oe, tail, longm;
  logic [CW-1:0] nsent;
  logic          done_ev;

  assign done_ev = tail | (b_fall && nsent == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '1;
      full   <= 1'b0;
      shreg  <= '0;
      active <= 1'b0;
      oe     <= 1'b0;
      tail   <= 1'b0;
      nsent  <= '0;
      longm  <= 1'b1;
    end else begin
      if (f_rise && !active) begin
        full <= 1'b0;
        if (longm) begin
          active <= 1'b1;
          shreg  <= hold;
          nsent  <= '0;
          if (bclk) begin
            oe    <= 1'b1;
            nsent <= CW'(1);
          end
        end
      end else if (active) begin
        if (b_rise) begin
          if (nsent == '0) begin
            oe    <= 1'b1;
            nsent <= CW'(1);
          end else if (nsent < LAST) begin
            shreg <= {shreg[DW-2:0], 1'b0};
            nsent <= nsent + 1'b1;
          end
        end
        if (b_fall && nsent == LAST) tail <= 1'b1;
        if (done_ev && !fs) begin
          oe     <= 1'b0;
          active <= 1'b0;
          tail   <= 1'b0;
        end
      end
      if (valid_i && !full) begin
        hold <= data_i;
        full <= 1'b1;
      end
      if (f_fall) longm <= (classify(width_d) == SYNC_LONG);
    end
  end

  assign ready_o = ~full;
  assign oe_o    = oe;
  assign dout_o  = oe & shreg[DW-1];
  assign long_o  = longm;
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          fs_i,
  input  logic          din_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          sig_o,
  output logic          err_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [2:0] s;
  logic bclk, fs, din, bclk_q, fs_q, b_fall, f_rise;
  logic [WIDTH_BITS-1:0] width_d;

  pcm_sync #(.N(3), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({din_i, fs_i, bclk_i}), .sync_o(s)
  );
  assign bclk = s[0];
  assign fs   = s[1];
  assign din  = s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      fs_q   <= fs;
    end
  end

  assign b_fall = ~bclk & bclk_q;
  assign f_rise = fs & ~fs_q;

  pcm_width_meter u_meter (
    .clk(clk), .rst_n(rst_n), .fs_rise(f_rise), .fs_lvl(fs),
    .bclk_fall(b_fall), .width_d(width_d)
  );

  logic          active;
  logic [CW-1:0] nrx;
  logic [DW-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      nrx     <= '0;
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      sig_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (f_rise) begin
        active <= 1'b1;
        nrx    <= '0;
      end else if (active && b_fall) begin
        shreg <= {shreg[DW-2:0], din};
        if (nrx == LAST) begin
          data_o  <= {shreg[DW-2:0], din};
          valid_o <= 1'b1;
          sig_o   <= (classify(width_d) == SYNC_SIG);
          err_o   <= (classify(width_d) == SYNC_RUNT);
          active  <= 1'b0;
        end else begin
          nrx <= nrx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_dec_timer.sv
module pcm_dec_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             strobe_o
);
  logic [DLY_W-1:0] cnt, eff;
  logic             busy;

  assign eff = (dly_i == '0) ? DLY_W'(1) : dly_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      busy     <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (start_i) begin
        cnt  <= eff;
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == DLY_W'(1)) begin
          strobe_o <= 1'b1;
          busy     <= 1'b0;
        end
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_lf_port.sv
module pcm_lf_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bclk,
  input  logic             tx_fsync,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_dout,
  output logic             tx_oe,
  output logic             tx_long,
  input  logic             rx_bclk,
  input  logic             rx_fsync,
  input  logic             rx_din,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             rx_sig,
  output logic             rx_err,
  input  logic [DLY_W-1:0] dec_dly,
  output logic             dec_strobe
);
  pcm_tx #(.DW(DW), .STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_n), .bclk_i(tx_bclk), .fs_i(tx_fsync),
    .data_i(tx_data), .valid_i(tx_valid), .ready_o(tx_ready),
    .dout_o(tx_dout), .oe_o(tx_oe), .long_o(tx_long)
  );

  pcm_rx #(.DW(DW), .STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(rx_bclk), .fs_i(rx_fsync),
    .din_i(rx_din), .data_o(rx_data), .valid_o(rx_valid),
    .sig_o(rx_sig), .err_o(rx_err)
  );

  pcm_dec_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(rx_valid), .dly_i(dec_dly),
    .strobe_o(dec_strobe)
  );
endmodule

// File: rtl/pcm_lf_port_chk.sv
module pcm_lf_port_chk #(
  parameter int DW    = 8,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_dout,
  input logic             tx_oe,
  input logic             tx_long,
  input logic             rx_valid,
  input logic             rx_sig,
  input logic             rx_err,
  input logic [DLY_W-1:0] dec_dly,
  input logic             dec_strobe
);
  logic [DLY_W:0] since;
  logic           seen;
  logic [DLY_W:0] want;

  assign want = ((dec_dly == '0) ? (DLY_W+1)'(1) : {1'b0, dec_dly}) + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (rx_valid) begin
      since <= (DLY_W+1)'(1);
      seen  <= 1'b1;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  a_r2_oe_only_long: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> tx_long);

  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_dout);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(rx_sig && rx_err));

  a_r9_strobe_delay: assert property (@(posedge clk) disable iff (!rst_n)
    dec_strobe |-> (seen && since == want));
endmodule

bind pcm_lf_port pcm_lf_port_chk #(.DW(DW), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_dout(tx_dout), .tx_oe(tx_oe), .tx_long(tx_long), .rx_valid(rx_valid),
  .rx_sig(rx_sig), .rx_err(rx_err), .dec_dly(dec_dly), .dec_strobe(dec_strobe)
);

// File: tb/sim_pcm_lf_port.sv
`timescale 1ns/1ps
module sim_pcm_lf_port;
  localparam int H = 128;  // bit clock half period, ns

  logic clk = 0, rst_n = 0;
  logic tx_bclk = 0, tx_fsync = 0, tx_valid = 0;
  logic [7:0] tx_data = 0;
  logic rx_bclk = 0, rx_fsync = 0, rx_din = 0;
  logic [7:0] dec_dly = 8'd12;
  logic tx_ready, tx_dout, tx_oe, tx_long, rx_valid, rx_sig, rx_err, dec_strobe;
  logic [7:0] rx_data;

  pcm_lf_port u0 (.*);

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit exp_long = 1;
  logic [7:0] last_tx = 8'hFF;

  // monitors on the falling system edge
  int cyc = 0, v_cnt = 0, v_cyc = 0, s_cnt = 0, s_cyc = 0;
  logic [7:0] got_data;
  bit got_sig, got_err;
  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin
      v_cnt++; v_cyc = cyc; got_data = rx_data; got_sig = rx_sig; got_err = rx_err;
    end
    if (dec_strobe) begin s_cnt++; s_cyc = cyc; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_oe(input bit armed, input int p, input int fsw);
    return armed && (p < 8 || p < fsw);
  endfunction

  function automatic int eff_dly(input logic [7:0] d);
    return (d == 0) ? 2 : d + 1;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    @(posedge clk); #1 tx_valid = 0;
    check(tx_ready == 0, "R3 ready low after accept", tx_ready, 0);
    last_tx = b;
  endtask

  // synchronous-mode frame: both halves share clocks and sync
  task automatic frame(input logic [7:0] rb, input int fsw);
    bit armed = exp_long;
    bit bad_bit = 0, bad_oe = 0;
    int fails0 = n_fail;
    v_cnt = 0; s_cnt = 0;
    for (int p = 0; p < 10; p++) begin
      tx_bclk = 1; rx_bclk = 1;
      if (p < 8) rx_din = rb[7-p];
      #10;
      if (p == 0) begin tx_fsync = 1; rx_fsync = 1; end
      if (p == fsw) begin tx_fsync = 0; rx_fsync = 0; end
      #(H - 14);
      if (tx_oe !== exp_oe(armed, p, fsw)) begin
        if (!bad_oe) check(0, (p < 8) ? "R2 oe during bits" : "R5 oe release", tx_oe, exp_oe(armed, p, fsw));
        bad_oe = 1;
      end
      if (armed && p < 8 && tx_dout !== last_tx[7-p]) begin
        if (!bad_bit) check(0, (p == 0) ? "R2 sign bit" : "R4 data bit", tx_dout, last_tx[7-p]);
        bad_bit = 1;
      end
      if (!armed && tx_dout !== 1'b0) begin
        if (!bad_bit) check(0, "R4 dout quiet", tx_dout, 0);
        bad_bit = 1;
      end
      #4; tx_bclk = 0; rx_bclk = 0;
      #H;
    end
    if (n_fail == fails0) check(1, "R2 R4 R5 frame", 0, 0);
    #(2*H);
    exp_long = (fsw >= 3);
    check(tx_long == exp_long, "R1 mode", tx_long, exp_long);
    check(tx_ready == 1, "R3 ready after frame start", tx_ready, 1);
    check(v_cnt == 1, "R6 one valid pulse", v_cnt, 1);
    check(got_data == rb, "R6 byte", got_data, rb);
    check(got_sig == (fsw == 2), "R7 signalling flag", got_sig, fsw == 2);
    check(got_err == (fsw < 2), "R8 error flag", got_err, fsw < 2);
    check(s_cnt == 1 && s_cyc - v_cyc == eff_dly(dec_dly), "R9 strobe delay",
          s_cyc - v_cyc, eff_dly(dec_dly));
  endtask

  // receive-only frame on its own clock
  task automatic rx_async(input logic [7:0] rb, input int fsw, input int hr);
    bit oe_seen = 0;
    v_cnt = 0;
    for (int p = 0; p < 10; p++) begin
      rx_bclk = 1;
      if (p < 8) rx_din = rb[7-p];
      #7;
      if (p == 0) rx_fsync = 1;
      if (p == fsw) rx_fsync = 0;
      #(hr - 7);
      if (tx_oe) oe_seen = 1;
      rx_bclk = 0;
      #hr;
    end
    #(4*hr);
    check(!oe_seen, "R10 tx idle", oe_seen, 0);
    check(v_cnt == 1 && got_data == rb, "R10 async byte", got_data, rb);
    check(got_sig == (fsw == 2) && got_err == (fsw < 2), "R10 async flags",
          {got_sig, got_err}, {fsw == 2, fsw < 2});
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #20 rst_n = 1;
    #20;
    check(tx_oe == 0 && tx_dout == 0, "R4 reset output off", tx_oe, 0);
    check(tx_ready == 1, "R3 reset ready", tx_ready, 1);
    check(tx_long == 1, "R1 reset long", tx_long, 1);
    check(rx_valid == 0 && dec_strobe == 0, "R6 reset idle", rx_valid, 0);

    push(8'hA5); frame(8'h3C, 8);
    push(8'h81); frame(8'hC3, 3);   // shortest long sync
    push(8'h5A); frame(8'h7E, 9);   // sync outlasts the bits
    push(8'h0F); frame(8'hE1, 2);   // signalling sync -> next frame silent
    push(8'h99); frame(8'h18, 8);   // not armed this frame
    push(8'h66); frame(8'h42, 1);   // runt sync
    frame(8'h24, 4);                // silent, restores long mode
    frame(8'hBD, 5);                // no new byte: resend 8'h66
    dec_dly = 0; push(8'h01); frame(8'h80, 6);
    dec_dly = 40;

    for (int i = 0; i < 16; i++) begin
      int fsw = 1 + $urandom_range(8, 0);
      logic [7:0] rb = 8'($urandom);
      if ($urandom_range(3, 0) != 0) push(8'($urandom));
      dec_dly = 8'($urandom_range(50, 0));
      frame(rb, fsw);
    end

    rx_async(8'hD2, 8, 88);
    rx_async(8'h4B, 2, 61);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule